// File: doc/BRIEF.md
# RTC Alarm and Periodic Interrupt Unit

This unit sits next to a calendar counter. It watches the live BCD time and the one-second strobe from that counter. From them it produces one level interrupt line. The line can be driven by two sources. The first is a full-date alarm, which compares seconds, minutes, hours, day, month and year. The second is a periodic event, with a period of one second, one minute, one hour or one day.

Software reaches the unit through a small register port with byte writes and a combinational read. The port holds six alarm registers, an interrupt configuration register and a status register. Status bits are cleared by writing 1 to them. The interrupt stays high for as long as an enabled status bit is pending.

The unit does not count time and knows no bus protocol. Its register port is a plain strobe with an address: there is no data stream, so it has no back-pressure and no handshake. The live time is a packed bus. Field i sits at bits [8i+7:8i], in the order seconds, minutes, hours, day, month, year, from field 0 to field 5. The `tick` strobe is high for one cycle, and in that cycle `time_bcd` already holds the new second.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is low.
- R2: The alarm registers sit at addresses 0x07 to 0x0C and hold seconds, minutes, hours, day, month and year, in that order. Each reads back what was last written to it. An address that maps to no register reads 0x00.
- R3: Status bit 2 (second event) is set on every cycle in which `tick` is high.
- R4: Status bit 3 (minute event) is set on a tick whose seconds field is 0x00. Bit 4 (hour event) is set on a tick whose seconds and minutes fields are both 0x00. Bit 5 (day event) is set on a tick whose seconds, minutes and hours fields are all 0x00.
- R5: Status bit 6 (alarm) is set on a tick only when all six live fields equal the six alarm registers. If any field differs, the bit is not set. If the fields are equal but `tick` is low, the bit is not set.
- R6: The status register is at address 0x0E. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a bit is set and cleared in the same cycle, the set wins. Bits 1:0 and bit 7 read 0.
- R7: The configuration register is at address 0x0F. Bits 1:0 select the period: 0 is seconds, 1 is minutes, 2 is hours and 3 is days. Bit 2 enables the periodic interrupt and bit 3 enables the alarm interrupt. Bits 7:4 read 0.
- R8: `irq` is high exactly when either of two conditions holds. The first is that status bit 6 and the alarm enable are both set. The second is that the status bit of the selected period and the periodic enable are both set. `irq` stays high until the status bit behind it is cleared, and each source can be masked on its own.
- R9: Writing the alarm registers does not clear a pending alarm status.
- R10: A status bit caused by a tick, and any `irq` change that follows from it, appears in the first cycle after the clock edge that sampled the tick. Register reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second strobe from the calendar counter |
| time_bcd | input | 48 | Live BCD time, field 0 (seconds) in the low byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
Each tick or register write is applied for exactly one clock edge. The status register and `irq` are due one cycle later. The bench drives its inputs on the falling edge and samples on the next falling edge, which falls inside that cycle. Reads need no clock, so the bench samples `reg_rdata` shortly after it sets the address. For the case where a set and a clear land on the same edge, the tick and the write are driven in one cycle, and the result is read in the next cycle.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DW      = 8;
  localparam int AW      = 5;
  localparam int NFIELD  = 6;
  localparam logic [AW-1:0] A_ALM_BASE = 5'h07;
  localparam logic [AW-1:0] A_STATUS   = 5'h0E;
  localparam logic [AW-1:0] A_CFG      = 5'h0F;
  localparam int ST_SEC = 2;
  localparam int ST_ALM = 6;
  typedef enum logic [1:0] {PER_SEC = 2'd0, PER_MIN = 2'd1, PER_HOUR = 2'd2, PER_DAY = 2'd3} period_e;
endpackage

// File: rtl/rtc_event_detect.sv
module rtc_event_detect #(
  parameter int DATA_W = 8
) (
  input  logic              tick,
  input  logic [DATA_W-1:0] sec,
  input  logic [DATA_W-1:0] min,
  input  logic [DATA_W-1:0] hour,
  output logic [3:0]        ev
);
  logic sec_zero, min_zero, hour_zero;
  always_comb begin
    sec_zero  = (sec  == '0);
    min_zero  = (min  == '0);
    hour_zero = (hour == '0);
    ev[0] = tick;
    ev[1] = tick & sec_zero;
    ev[2] = tick & sec_zero & min_zero;
    ev[3] = tick & sec_zero & min_zero & hour_zero;
  end
endmodule

// File: rtl/rtc_alarm_bank.sv
module rtc_alarm_bank #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 5,
  parameter int NUM_FIELDS = 6,
  parameter logic [ADDR_W-1:0] BASE = 5'h07
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NUM_FIELDS*DATA_W-1:0] live,
  output logic                         rd_hit,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         match
);
  logic [DATA_W-1:0]     alm_q [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] eq;
  logic [NUM_FIELDS-1:0] sel;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    assign sel[i] = (addr == BASE + ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)             alm_q[i] <= '0;
      else if (we && sel[i])  alm_q[i] <= wdata;
    end
    assign eq[i] = (alm_q[i] == live[i*DATA_W +: DATA_W]);
  end

  assign match  = &eq;
  assign rd_hit = |sel;

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_FIELDS; k++)
      if (sel[k]) rd_data = alm_q[k];
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  input  logic [3:0]        ev,
  input  logic              alarm_match,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] cfg,
  output logic              irq
);
  logic [DATA_W-1:0] st_q, st_set, st_clr;
  period_e           per_q;
  logic              tim_en_q, alm_en_q;
  logic              per_flag;

  always_comb begin
    st_set = '0;
    st_set[ST_SEC +: 4] = ev;
    st_set[ST_ALM]      = tick & alarm_match;
    st_clr = (we && addr == A_STATUS) ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= '0;
      per_q    <= PER_SEC;
      tim_en_q <= 1'b0;
      alm_en_q <= 1'b0;
    end else begin
      st_q <= (st_q & ~st_clr) | st_set;
      if (we && addr == A_CFG) begin
        per_q    <= period_e'(wdata[1:0]);
        tim_en_q <= wdata[2];
        alm_en_q <= wdata[3];
      end
    end
  end

  always_comb begin
    per_flag = st_q[ST_SEC + int'(per_q)];
    irq      = (st_q[ST_ALM] & alm_en_q) | (per_flag & tim_en_q);
    status   = st_q;
    cfg      = '0;
    cfg[1:0] = per_q;
    cfg[2]   = tim_en_q;
    cfg[3]   = alm_en_q;
  end
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W     = DW,
  parameter int ADDR_W     = AW,
  parameter int NUM_FIELDS = NFIELD
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic [NUM_FIELDS*DATA_W-1:0] time_bcd,
  input  logic                         reg_we,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [DATA_W-1:0]            reg_rdata,
  output logic                         irq
);
  logic [3:0]        ev;
  logic              alarm_match;
  logic              alm_hit;
  logic [DATA_W-1:0] alm_rd;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] irq_cfg;

  rtc_event_detect #(.DATA_W(DATA_W)) u_ev (
    .tick (tick),
    .sec  (time_bcd[0*DATA_W +: DATA_W]),
    .min  (time_bcd[1*DATA_W +: DATA_W]),
    .hour (time_bcd[2*DATA_W +: DATA_W]),
    .ev   (ev)
  );

  rtc_alarm_bank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_FIELDS(NUM_FIELDS), .BASE(A_ALM_BASE)
  ) u_alm (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .live(time_bcd), .rd_hit(alm_hit), .rd_data(alm_rd), .match(alarm_match)
  );

  rtc_irq_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .tick(tick), .ev(ev), .alarm_match(alarm_match),
    .status(status_q), .cfg(irq_cfg), .irq(irq)
  );

  always_comb begin
    if (alm_hit)                   reg_rdata = alm_rd;
    else if (reg_addr == A_STATUS) reg_rdata = status_q;
    else if (reg_addr == A_CFG)    reg_rdata = irq_cfg;
    else                           reg_rdata = '0;
  end
endmodule

// File: rtl/rtc_irq_unit_chk.sv
module rtc_irq_unit_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              alarm_match,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] status,
  input logic [DATA_W-1:0] cfg,
  input logic              irq
);
  a_r5_alarm_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> $past(tick && alarm_match));

  a_r4_minute_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> $past(tick));

  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 5'h0E && reg_wdata[6] && !(tick && alarm_match)) |=> !status[6]);

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cfg[2] || cfg[3]));

  a_r8_alarm_level: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] && cfg[3]) |-> irq);

  a_r6_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1:0] == 2'b00) && !status[7]);
endmodule

bind rtc_irq_unit rtc_irq_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .alarm_match(alarm_match),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .status(status_q), .cfg(irq_cfg), .irq(irq)
);

// File: tb/rtc_irq_unit_tb.sv
`timescale 1ns/1ps
module rtc_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [47:0] time_bcd = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .time_bcd(time_bcd),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [47:0] mk(input logic [7:0] y, mo, d, h, mi, s);
    return {y, mo, d, h, mi, s};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic do_tick(input logic [47:0] t);
    time_bcd = t; tick = 1'b1;
    @(posedge clk); @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), v);
      check("R1 reset register", v, 8'h00);
    end
    check("R1 reset irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    for (int i = 0; i < 6; i++) wr(5'(7 + i), 8'h11 * 8'(i + 1));
    for (int i = 0; i < 6; i++) begin
      rd(5'(7 + i), v);
      check("R2 alarm readback", v, 8'h11 * 8'(i + 1));
    end
    rd(5'h0D, v); check("R2 unmapped 0x0D", v, 8'h00);
    rd(5'h06, v); check("R2 unmapped 0x06", v, 8'h00);
    wr(5'h0F, 8'hFF);
    rd(5'h0F, v); check("R7 cfg upper bits zero", v, 8'h0F);
    wr(5'h0F, 8'h00);
  endtask

  task automatic t_periodic();
    logic [7:0] v;
    wr(5'h0E, 8'hFF);
    do_tick(mk(8'h24, 8'h05, 8'h10, 8'h12, 8'h34, 8'h56));
    rd(5'h0E, v); check("R3 second event", v, 8'h04);
    wr(5'h0E, 8'hFF);
    do_tick(mk(8'h24, 8'h05, 8'h10, 8'h12, 8'h34, 8'h00));
    rd(5'h0E, v); check("R4 minute event", v, 8'h0C);
    wr(5'h0E, 8'hFF);
    do_tick(mk(8'h24, 8'h05, 8'h10, 8'h05, 8'h00, 8'h00));
    rd(5'h0E, v); check("R4 hour event", v, 8'h1C);
    wr(5'h0E, 8'hFF);
    do_tick(mk(8'h24, 8'h05, 8'h11, 8'h00, 8'h00, 8'h00));
    rd(5'h0E, v); check("R4 day event", v, 8'h3C);
    wr(5'h0E, 8'h00);
    rd(5'h0E, v); check("R6 write zero keeps bits", v, 8'h3C);
    wr(5'h0E, 8'hFF);
    rd(5'h0E, v); check("R6 write one clears", v, 8'h00);
  endtask

  task automatic t_irq_select();
    logic [7:0] v;
    wr(5'h0F, 8'h05);
    do_tick(mk(8'h24, 8'h05, 8'h11, 8'h00, 8'h00, 8'h05));
    check("R8 minute period, no rollover", {7'b0, irq}, 8'h00);
    do_tick(mk(8'h24, 8'h05, 8'h11, 8'h00, 8'h01, 8'h00));
    check("R8 R10 minute period fires", {7'b0, irq}, 8'h01);
    wr(5'h0E, 8'h04);
    check("R8 seconds clear keeps minute irq", {7'b0, irq}, 8'h01);
    wr(5'h0E, 8'h08);
    check("R8 minute clear drops irq", {7'b0, irq}, 8'h00);
    wr(5'h0F, 8'h01);
    do_tick(mk(8'h24, 8'h05, 8'h11, 8'h00, 8'h02, 8'h00));
    check("R8 periodic masked", {7'b0, irq}, 8'h00);
    wr(5'h0F, 8'h04);
    check("R7 R8 seconds period fires on pending", {7'b0, irq}, 8'h01);
    wr(5'h0F, 8'h00);
    wr(5'h0E, 8'hFF);
  endtask

  task automatic t_alarm();
    logic [7:0] v;
    logic [47:0] hit;
    hit = mk(8'h24, 8'h06, 8'h21, 8'h08, 8'h15, 8'h30);
    wr(5'h07, 8'h30); wr(5'h08, 8'h15); wr(5'h09, 8'h08);
    wr(5'h0A, 8'h21); wr(5'h0B, 8'h06); wr(5'h0C, 8'h24);
    wr(5'h0F, 8'h08);
    wr(5'h0E, 8'hFF);
    do_tick(mk(8'h25, 8'h06, 8'h21, 8'h08, 8'h15, 8'h30));
    rd(5'h0E, v); check("R5 year differs no alarm", v, 8'h04);
    check("R5 no irq on mismatch", {7'b0, irq}, 8'h00);
    time_bcd = hit;
    @(posedge clk); @(negedge clk);
    rd(5'h0E, v); check("R5 equal without tick", v, 8'h04);
    wr(5'h0E, 8'hFF);
    do_tick(hit);
    rd(5'h0E, v); check("R5 R10 alarm match", v, 8'h44);
    check("R8 alarm irq", {7'b0, irq}, 8'h01);
    do_tick(mk(8'h24, 8'h06, 8'h21, 8'h08, 8'h15, 8'h31));
    check("R8 irq level holds", {7'b0, irq}, 8'h01);
    wr(5'h07, 8'h45);
    rd(5'h0E, v); check("R9 alarm write keeps status", {7'b0, v[6]}, 8'h01);
    check("R9 irq still high", {7'b0, irq}, 8'h01);
    wr(5'h0E, 8'h40);
    check("R6 alarm clear drops irq", {7'b0, irq}, 8'h00);
    wr(5'h07, 8'h30);
    wr(5'h0E, 8'hFF);
    time_bcd = hit; tick = 1'b1;
    reg_we = 1'b1; reg_addr = 5'h0E; reg_wdata = 8'h40;
    @(posedge clk); @(negedge clk);
    tick = 1'b0; reg_we = 1'b0;
    rd(5'h0E, v); check("R6 set wins over clear", v, 8'h44);
    wr(5'h0F, 8'h04);
    check("R8 alarm masked, seconds irq", {7'b0, irq}, 8'h01);
    wr(5'h0E, 8'h04);
    check("R8 alarm masked, pending alarm ignored", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_periodic();
    t_irq_select();
    t_alarm();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule